// File: doc/BRIEF.md
# Five-Source Interrupt Status Controller

This block merges five interrupt conditions into a single registered interrupt request for a host. Two conditions are live ready flags from the two port groups. Two are one-cycle terminal-count pulses from the DMA channels of the two groups. The fifth is a 0-to-1 transition on a free-running counter output, which is asynchronous to the block clock.

Each condition has an enable bit and a status bit. The interrupt request is high when any condition has both its status bit and its enable bit set. The two ready flags show in the status register exactly as the ports present them, and they fall when the port is read. The three event conditions are held in sticky status bits. Software clears a sticky bit by writing a one to its position in a separate clear register.

Software uses a small register bus. A write is a single-cycle strobe. Read data is combinational from the address. Offset 0 holds the enables, offset 1 the status, and offset 2 the clear register. In every register, bit 0 is ready group 1, bit 1 is ready group 2, bit 2 is terminal count group 1, bit 3 is terminal count group 2, and bit 4 is the counter edge.

Top module: `irq5_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the enable register, every sticky status bit and `irq_o` are 0.
- R2: A bus write to offset 0 loads bits [4:0] of the write data into the enable register, on the clock edge of the write. A read of offset 0 returns the enables in bits [4:0] and zeros above them.
- R3: A read of offset 1 returns bit 0 = `rdy_g1` and bit 1 = `rdy_g2`, taken in the same cycle from the inputs. It returns the three sticky bits in positions 2 to 4 and zeros above them. A read of offset 2 or offset 3 returns 0.
- R4: A high cycle on `tc_g1` sets status bit 2 on that clock edge, and a high cycle on `tc_g2` sets status bit 3 on that clock edge. Each bit then holds until it is cleared.
- R5: A 0-to-1 change of `cnt_out` sets status bit 4 on the second clock edge after the edge that first samples it high. A steady high level, or a 1-to-0 change, sets nothing.
- R6: A write to offset 2 clears each sticky bit (bits 2 to 4) whose write-data bit is 1. Write-data bits that are 0, and write-data bits 0 and 1, change nothing.
- R7: If an event and the clear of the same bit occur in the same cycle, the bit is set after that edge.
- R8: `irq_o` is registered. After each clock edge it equals the OR over all five sources of (status AND enable), as they stood before that edge.
- R9: Writes to offset 1 or offset 3 change neither the enables nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (2) | Register offset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for `bus_addr`, combinational |
| rdy_g1 | input | 1 | Ready flag of port group 1, a level |
| rdy_g2 | input | 1 | Ready flag of port group 2, a level |
| tc_g1 | input | 1 | Terminal-count pulse, DMA group 1 |
| tc_g2 | input | 1 | Terminal-count pulse, DMA group 2 |
| cnt_out | input | 1 | Raw counter output, asynchronous |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check the following on every cycle:
- the registered relation between `irq_o` and status AND enable;
- the setting of a sticky bit by its event, including when a clear arrives in the same cycle;
- the hold of a sticky bit when no clear arrives, and its release when a clear arrives;
- the stability of the enables outside writes to offset 0.

Only the bench scenarios can show the following:
- the exact latency from a change on `cnt_out` to status bit 4;
- that a steady level or a falling edge on `cnt_out` sets nothing;
- that clear bits 0 and 1 and writes to the read-only offsets have no effect;
- that the ready flags reach the status read in the same cycle.

// File: rtl/irq5_pkg.sv
package irq5_pkg;
  localparam int NSRC = 5;

  localparam int SRC_RDY1 = 0;
  localparam int SRC_RDY2 = 1;
  localparam int SRC_TC1  = 2;
  localparam int SRC_TC2  = 3;
  localparam int SRC_CNT  = 4;

  localparam int OFS_ENABLE = 0;
  localparam int OFS_STATUS = 1;
  localparam int OFS_CLEAR  = 2;

  typedef logic [NSRC-1:0] src_vec_t;

  // positions held in sticky flops (event sources)
  localparam src_vec_t STICKY_MASK = 5'b11100;

  function automatic logic sticky_next(logic q, logic clr, logic evt);
    return (q & ~clr) | evt;
  endfunction

  function automatic logic irq_any(src_vec_t st, src_vec_t en);
    return |(st & en);
  endfunction

  function automatic logic rise_of(logic now_v, logic before_v);
    return now_v & ~before_v;
  endfunction
endpackage

// File: rtl/irq5_edge_sync.sv
module irq5_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);
  import irq5_pkg::*;

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise_o = rise_of(sync_q[LAST], prev_q);
endmodule

// File: rtl/irq5_sources.sv
module irq5_sources (
  input  logic                clk,
  input  logic                rst_n,
  input  irq5_pkg::src_vec_t  evt_i,
  input  irq5_pkg::src_vec_t  clr_i,
  output irq5_pkg::src_vec_t  sticky_o
);
  import irq5_pkg::*;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (STICKY_MASK[i]) begin : g_sticky
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= sticky_next(bit_q, clr_i[i], evt_i[i]);
      end
      assign sticky_o[i] = bit_q;
    end else begin : g_level
      assign sticky_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq5_regif.sv
module irq5_regif #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  irq5_pkg::src_vec_t  status_i,
  output irq5_pkg::src_vec_t  en_o,
  output logic                en_wr_o,
  output irq5_pkg::src_vec_t  clr_o,
  output logic [DATA_W-1:0]   bus_rdata
);
  import irq5_pkg::*;

  localparam int PAD_W = DATA_W - NSRC;

  logic     sel_en, sel_st, sel_clr;
  src_vec_t en_q;

  assign sel_en  = (bus_addr == ADDR_W'(OFS_ENABLE));
  assign sel_st  = (bus_addr == ADDR_W'(OFS_STATUS));
  assign sel_clr = (bus_addr == ADDR_W'(OFS_CLEAR));

  assign en_wr_o = bus_wr & sel_en;
  assign clr_o   = (bus_wr & sel_clr) ? (bus_wdata[NSRC-1:0] & STICKY_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_wr_o) en_q <= bus_wdata[NSRC-1:0];
  end

  assign en_o = en_q;

  always_comb begin
    bus_rdata = '0;
    if (sel_en)      bus_rdata = {{PAD_W{1'b0}}, en_q};
    else if (sel_st) bus_rdata = {{PAD_W{1'b0}}, status_i};
  end
endmodule

// File: rtl/irq5_ctrl.sv
module irq5_ctrl #(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rdy_g1,
  input  logic              rdy_g2,
  input  logic              tc_g1,
  input  logic              tc_g2,
  input  logic              cnt_out,
  output logic              irq_o
);
  import irq5_pkg::*;

  logic     cnt_edge_w;
  src_vec_t evt_w, clr_w, sticky_w, status_w, en_w;
  logic     en_wr_w;
  logic     irq_q;

  irq5_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(cnt_out), .rise_o(cnt_edge_w)
  );

  always_comb begin
    evt_w          = '0;
    evt_w[SRC_TC1] = tc_g1;
    evt_w[SRC_TC2] = tc_g2;
    evt_w[SRC_CNT] = cnt_edge_w;
  end

  irq5_sources u_src (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_w), .clr_i(clr_w), .sticky_o(sticky_w)
  );

  always_comb begin
    status_w           = sticky_w;
    status_w[SRC_RDY1] = rdy_g1;
    status_w[SRC_RDY2] = rdy_g2;
  end

  irq5_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .status_i(status_w), .en_o(en_w),
    .en_wr_o(en_wr_w), .clr_o(clr_w), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_any(status_w, en_w);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq5_ctrl_chk.sv
module irq5_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] status,
  input logic [4:0] sticky,
  input logic [4:0] en,
  input logic [4:0] evt,
  input logic [4:0] clr,
  input logic       en_wr,
  input logic       irq
);
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status & en))));

  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[2] || evt[3]) |=> ((sticky[3:2] & $past(evt[3:2])) == $past(evt[3:2])));

  p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt[4] |=> sticky[4]);

  p_event_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[2] && clr[2]) |=> sticky[2]);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky[2] && !clr[2]) |=> sticky[2]);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[3] && !evt[3]) |=> !sticky[3]);

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sticky[2] && !evt[2]) |=> !sticky[2]);

  p_enable_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en));

  p_level_not_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sticky[1:0] == 2'b00);
endmodule

bind irq5_ctrl irq5_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status_w), .sticky(sticky_w),
  .en(en_w), .evt(evt_w), .clr(clr_w), .en_wr(en_wr_w), .irq(irq_o)
);

// File: tb/irq5_ctrl_test.sv
module irq5_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rdy_g1 = 0, rdy_g2 = 0, tc_g1 = 0, tc_g2 = 0, cnt_out = 0;
  logic       irq_o;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  always #5 clk = ~clk;

  irq5_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rdy_g1(rdy_g1),
    .rdy_g2(rdy_g2), .tc_g1(tc_g1), .tc_g2(tc_g2), .cnt_out(cnt_out),
    .irq_o(irq_o)
  );

  // behavioural reference
  int   m_en = 0;
  int   m_ev = 0;        // bit 2,3,4 event flags
  bit   m_irq = 0;
  bit   hist[$] = '{0, 0, 0};

  function automatic int status_now();
    return m_ev | (int'(rdy_g2) << 1) | int'(rdy_g1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ev = 0; m_irq = 0; hist = '{0, 0, 0};
    end else begin
      int st, nxt, clrm;
      bit edge_seen;
      st = status_now();
      m_irq = ((st & m_en) != 0);
      edge_seen = hist[1] && !hist[2];
      clrm = (bus_wr && bus_addr == 2) ? (int'(bus_wdata) & 'h1C) : 0;
      nxt = m_ev & ~clrm;
      if (tc_g1) nxt |= 'h04;
      if (tc_g2) nxt |= 'h08;
      if (edge_seen) nxt |= 'h10;
      m_ev = nxt;
      if (bus_wr && bus_addr == 0) m_en = int'(bus_wdata) & 'h1F;
      hist.push_front(cnt_out);
      void'(hist.pop_back());
    end
  end

  function automatic int exp_rdata();
    case (bus_addr)
      2'd0:    return m_en;
      2'd1:    return status_now();
      default: return 0;
    endcase
  endfunction

  task automatic cyc();
    @(negedge clk);
    n_cmp++;
    if (irq_o !== m_irq) begin
      n_bad++;
      $display("FAIL %s irq_o got %0b expected %0b at %0t", tag, irq_o, m_irq, $time);
    end
    n_cmp++;
    if (int'(bus_rdata) != exp_rdata() || $isunknown(bus_rdata)) begin
      n_bad++;
      $display("FAIL %s rdata@%0d got %02h expected %02h at %0t",
               tag, bus_addr, bus_rdata, exp_rdata(), $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    cyc();
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    tag = "R1"; bus_addr = 2'd1;
    rdy_g1 = 1;
    idle(3);
    rst_n = 1;
    rdy_g1 = 0;
    idle(2);
    bus_addr = 0; idle(1);

    tag = "R2";
    wr(0, 8'hFF); idle(2);
    wr(0, 8'h0A); idle(1);
    wr(0, 8'h00); idle(1);

    tag = "R3";
    bus_addr = 1; rdy_g1 = 1; idle(1);
    rdy_g2 = 1; idle(1);
    rdy_g1 = 0; idle(1);
    rdy_g2 = 0; idle(1);
    bus_addr = 2; idle(1);
    bus_addr = 3; idle(1);

    tag = "R4";
    bus_addr = 1;
    tc_g1 = 1; cyc(); tc_g1 = 0; idle(4);
    tc_g2 = 1; cyc(); tc_g2 = 0; idle(3);

    tag = "R9";
    wr(1, 8'hFF); idle(1);
    wr(3, 8'hFF); bus_addr = 0; idle(1);
    bus_addr = 1; idle(1);

    tag = "R6";
    rdy_g1 = 1; rdy_g2 = 1;
    wr(2, 8'h03); bus_addr = 1; idle(1);
    wr(2, 8'h04); bus_addr = 1; idle(2);
    wr(2, 8'hE8); bus_addr = 1; idle(2);
    rdy_g1 = 0; rdy_g2 = 0; idle(1);

    tag = "R7";
    tc_g1 = 1; wr(2, 8'h04); tc_g1 = 0; bus_addr = 1; idle(2);
    wr(2, 8'h04); bus_addr = 1; idle(1);

    tag = "R5";
    cnt_out = 1; idle(6);
    wr(2, 8'h10); bus_addr = 1; idle(5);
    cnt_out = 0; idle(5);
    cnt_out = 1; cyc(); cnt_out = 0; idle(5);
    wr(2, 8'h10); bus_addr = 1; idle(2);

    tag = "R8";
    wr(0, 8'h08); bus_addr = 1; idle(1);
    tc_g2 = 1; cyc(); tc_g2 = 0; idle(3);
    wr(0, 8'h00); bus_addr = 1; idle(2);
    wr(0, 8'h01); bus_addr = 1; idle(1);
    rdy_g1 = 1; idle(2);
    rdy_g1 = 0; idle(2);
    wr(0, 8'h10); cnt_out = 1; bus_addr = 1; idle(5);
    wr(2, 8'h1C); bus_addr = 1; idle(3);
    cnt_out = 0; idle(2);

    tag = "R1";
    rst_n = 0; idle(2);
    rst_n = 1; idle(2);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired under %s", tag);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule